// File: doc/BRIEF.md
# Reset and Interrupt Entry Sequencer

This block steers the two ways an 8-bit processor with a 16-bit address space can be forced to a new program address without decoding an instruction. After reset it reads a two-byte start address from the top of memory and loads it into the program counter, and it sets the interrupt mask. After that it sits idle and watches a level-sensitive interrupt request.

When a request arrives while the mask bit of the condition code byte is clear, the sequencer saves the whole register set to the stack. It writes seven bytes, one per cycle, walking down from the current stack pointer. It then reads a two-byte handler address from a fixed vector, loads it into the program counter and sets the mask bit. The register file is outside the block: its values come in on input ports, and the block returns updates through load strobes for the program counter, the stack pointer and the mask bit. Memory is a byte-wide synchronous port, so read data arrives one cycle after the address. A free-running cycle counter restarts from zero at reset, so every operation adds its own length to it.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_n` is low, `mem_wr` and `pc_load` are 0, `busy` is 1 and `cycle_count` is 0.
- R2: After reset is released, the block reads address 0xFFFE in the first cycle and 0xFFFF in the second. In the third cycle it pulses `pc_load` with `pc_value` = {byte at 0xFFFE, byte at 0xFFFF}, the high byte taken from the lower address.
- R3: Every `pc_load` pulse, after reset or after an interrupt, comes with `iflag_set` = 1 in the same cycle, so the mask bit is set.
- R4: `cycle_count` is 0 in the first cycle after reset release and then rises by exactly one per clock.
- R5: While bit 4 of `ccr_in` (the mask bit) is 1, a high `irq_req` starts no entry: no memory write takes place and `busy` stays 0.
- R6: An accepted request produces seven writes on consecutive cycles, starting the cycle after acceptance. Their addresses are SP, SP-1, ... SP-6, modulo 2^16. Their data, in order, is PC low, PC high, X low, X high, A, B, CCR, using the register values at acceptance.
- R7: In each write cycle `sp_load` is 1 and `sp_value` equals the write address minus one, so SP finishes 7 below its value at acceptance, wrapping below 0x0000.
- R8: After the last write the block reads 0xFFF8 and then 0xFFF9. In the next cycle it pulses `pc_load` with `pc_value` = {byte at 0xFFF8, byte at 0xFFF9}.
- R9: `busy` is 1 from the cycle after acceptance up to and including the `pc_load` cycle of the vector fetch. Requests during that time are ignored. A request held high afterwards starts a new entry only after the mask bit has been cleared.
- R10: Asserting reset during an entry stops the writes at once. On release the block starts again with the reset fetch from 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Level interrupt request |
| pc_in | input | 16 | Address of the next instruction |
| x_in | input | 16 | Index register |
| a_in | input | 8 | First accumulator |
| b_in | input | 8 | Second accumulator |
| ccr_in | input | 8 | Condition code byte, bit 4 is the mask |
| sp_in | input | 16 | Stack pointer |
| mem_rdata | input | 8 | Read data, valid one cycle after a read |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| pc_load | output | 1 | Load strobe for the program counter |
| pc_value | output | 16 | New program counter value |
| sp_load | output | 1 | Load strobe for the stack pointer |
| sp_value | output | 16 | New stack pointer value |
| iflag_set | output | 1 | Set the mask bit |
| busy | output | 1 | Sequence in progress |
| cycle_count | output | 32 | Clock cycles since reset |

## Verification
Two events can meet in one cycle: the mask bit being set at the end of the reset fetch, and an interrupt request that was already pending. The bench holds `irq_req` high through a whole reset with the mask bit clear beforehand. It then checks that the program counter receives the reset vector and that no stack write follows in the next cycles, because the mask becomes 1 in the same edge that returns the block to idle. A second meeting is a request held high across the final vector cycle of an entry; it must produce no new entry until the mask bit is cleared again. The test where reset cuts an entry in the middle judges the reverse case, where reset wins over a running push.

// File: rtl/seq_pkg.sv
package seq_pkg;

   typedef enum logic [2:0] {
      S_RV_HI,
      S_RV_LO,
      S_RV_LD,
      S_IDLE,
      S_PUSH,
      S_IV_HI,
      S_IV_LO,
      S_IV_LD
   } seq_st_t;

   localparam int PUSH_BYTES = 7;

endpackage

// File: rtl/seq_cycle_cnt.sv
module seq_cycle_cnt #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] count
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign count = cnt_q;

   assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/seq_push_sel.sv
module seq_push_sel import seq_pkg::*; #(
   parameter int DW       = 8,
   parameter int AW       = 16,
   parameter bit SNAPSHOT = 1,
   localparam int IW      = $clog2(PUSH_BYTES),
   localparam int NSLOT   = 1 << IW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          snap_en,
   input  logic [AW-1:0] pc_in,
   input  logic [AW-1:0] x_in,
   input  logic [DW-1:0] a_in,
   input  logic [DW-1:0] b_in,
   input  logic [DW-1:0] ccr_in,
   input  logic [IW-1:0] idx,
   output logic [DW-1:0] wdata
);

   logic [AW-1:0] pc_s, x_s;
   logic [DW-1:0] a_s, b_s, ccr_s;
   logic [DW-1:0] slot [NSLOT];

   generate
      if (SNAPSHOT) begin : g_snap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pc_s  <= '0;
               x_s   <= '0;
               a_s   <= '0;
               b_s   <= '0;
               ccr_s <= '0;
            end else if (snap_en) begin
               pc_s  <= pc_in;
               x_s   <= x_in;
               a_s   <= a_in;
               b_s   <= b_in;
               ccr_s <= ccr_in;
            end
         end
      end else begin : g_live
         assign pc_s  = pc_in;
         assign x_s   = x_in;
         assign a_s   = a_in;
         assign b_s   = b_in;
         assign ccr_s = ccr_in;
      end
   endgenerate

   // stack image, lowest index written first (at the highest address)
   always_comb begin
      for (int i = 0; i < NSLOT; i++) slot[i] = '0;
      slot[0] = pc_s[DW-1:0];
      slot[1] = pc_s[AW-1:DW];
      slot[2] = x_s[DW-1:0];
      slot[3] = x_s[AW-1:DW];
      slot[4] = a_s;
      slot[5] = b_s;
      slot[6] = ccr_s;
   end

   assign wdata = slot[idx];

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl import seq_pkg::*; #(
   parameter int           DW            = 8,
   parameter int           AW            = 16,
   parameter logic [AW-1:0] RST_VEC      = 16'hFFFE,
   parameter logic [AW-1:0] IRQ_VEC      = 16'hFFF8,
   parameter bit           SP_EACH_WRITE = 1,
   localparam int          IW            = $clog2(PUSH_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          irq_req,
   input  logic          mask_i,
   input  logic [AW-1:0] sp_in,
   input  logic [DW-1:0] rdata,
   output logic          snap_en,
   output logic [IW-1:0] push_idx,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic          pc_load,
   output logic [AW-1:0] pc_value,
   output logic          sp_load,
   output logic [AW-1:0] sp_value,
   output logic          iflag_set,
   output logic          busy
);

   localparam logic [AW-1:0] ONE      = AW'(1);
   localparam logic [IW-1:0] LAST_IDX = IW'(PUSH_BYTES - 1);

   seq_st_t       st_q, st_d;
   logic [IW-1:0] idx_q;
   logic [AW-1:0] ptr_q;
   logic [DW-1:0] hi_q;
   logic          accept;

   assign accept = (st_q == S_IDLE) && irq_req && !mask_i;

   always_comb begin
      st_d = st_q;
      case (st_q)
         S_RV_HI: st_d = S_RV_LO;
         S_RV_LO: st_d = S_RV_LD;
         S_RV_LD: st_d = S_IDLE;
         S_IDLE:  if (accept) st_d = S_PUSH;
         S_PUSH:  if (idx_q == LAST_IDX) st_d = S_IV_HI;
         S_IV_HI: st_d = S_IV_LO;
         S_IV_LO: st_d = S_IV_LD;
         S_IV_LD: st_d = S_IDLE;
         default: st_d = S_RV_HI;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= S_RV_HI;
         idx_q <= '0;
         ptr_q <= '0;
         hi_q  <= '0;
      end else begin
         st_q <= st_d;
         case (st_q)
            S_IDLE: if (accept) begin
               ptr_q <= sp_in;
               idx_q <= '0;
            end
            S_PUSH: begin
               ptr_q <= ptr_q - ONE;
               idx_q <= idx_q + 1'b1;
            end
            S_RV_LO, S_IV_LO: hi_q <= rdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      mem_addr = '0;
      case (st_q)
         S_RV_HI: mem_addr = RST_VEC;
         S_RV_LO: mem_addr = RST_VEC + ONE;
         S_IV_HI: mem_addr = IRQ_VEC;
         S_IV_LO: mem_addr = IRQ_VEC + ONE;
         S_PUSH:  mem_addr = ptr_q;
         default: mem_addr = '0;
      endcase
   end

   assign mem_rd    = (st_q == S_RV_HI) || (st_q == S_RV_LO) ||
                      (st_q == S_IV_HI) || (st_q == S_IV_LO);
   assign mem_wr    = (st_q == S_PUSH);
   assign pc_load   = (st_q == S_RV_LD) || (st_q == S_IV_LD);
   assign pc_value  = {hi_q, rdata};
   assign iflag_set = pc_load;
   assign busy      = (st_q != S_IDLE);
   assign snap_en   = accept;
   assign push_idx  = idx_q;

   generate
      if (SP_EACH_WRITE) begin : g_sp_step
         assign sp_load  = (st_q == S_PUSH);
         assign sp_value = ptr_q - ONE;

         assert_sp_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
            mem_wr |-> (sp_load && (sp_value == mem_addr - ONE)));
      end else begin : g_sp_once
         assign sp_load  = (st_q == S_PUSH) && (idx_q == LAST_IDX);
         assign sp_value = ptr_q - ONE;
      end
   endgenerate

   assert_push_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && idx_q != LAST_IDX) |=> (mem_wr && mem_addr == $past(mem_addr) - ONE));

   assert_masked_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_IDLE && mask_i) |=> !mem_wr);

   assert_pc_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> iflag_set);

   assert_vec_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && mem_addr == IRQ_VEC) |=> (mem_rd && mem_addr == IRQ_VEC + ONE));

   assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(pc_load));

   assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq import seq_pkg::*; #(
   parameter int            DW            = 8,
   parameter int            AW            = 16,
   parameter int            CNT_W         = 32,
   parameter int            MASK_BIT      = 4,
   parameter logic [AW-1:0] RST_VEC       = 16'hFFFE,
   parameter logic [AW-1:0] IRQ_VEC       = 16'hFFF8,
   parameter bit            SP_EACH_WRITE = 1,
   parameter bit            SNAPSHOT      = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_req,
   input  logic [AW-1:0]    pc_in,
   input  logic [AW-1:0]    x_in,
   input  logic [DW-1:0]    a_in,
   input  logic [DW-1:0]    b_in,
   input  logic [DW-1:0]    ccr_in,
   input  logic [AW-1:0]    sp_in,
   input  logic [DW-1:0]    mem_rdata,
   output logic [AW-1:0]    mem_addr,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic [DW-1:0]    mem_wdata,
   output logic             pc_load,
   output logic [AW-1:0]    pc_value,
   output logic             sp_load,
   output logic [AW-1:0]    sp_value,
   output logic             iflag_set,
   output logic             busy,
   output logic [CNT_W-1:0] cycle_count
);

   localparam int IW = $clog2(PUSH_BYTES);

   generate
      if (AW != 2 * DW) begin : g_bad_width
         $error("address width must be twice the data width");
      end
      if (MASK_BIT < 0 || MASK_BIT >= DW) begin : g_bad_mask
         $error("mask bit position outside the condition byte");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("cycle counter needs at least one bit");
      end
   endgenerate

   logic          snap_en;
   logic [IW-1:0] push_idx;

   seq_ctrl #(
      .DW(DW), .AW(AW), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC),
      .SP_EACH_WRITE(SP_EACH_WRITE)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
      .mask_i(ccr_in[MASK_BIT]), .sp_in(sp_in), .rdata(mem_rdata),
      .snap_en(snap_en), .push_idx(push_idx),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .pc_load(pc_load), .pc_value(pc_value),
      .sp_load(sp_load), .sp_value(sp_value),
      .iflag_set(iflag_set), .busy(busy)
   );

   seq_push_sel #(
      .DW(DW), .AW(AW), .SNAPSHOT(SNAPSHOT)
   ) u_sel (
      .clk(clk), .rst_n(rst_n), .snap_en(snap_en),
      .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .b_in(b_in), .ccr_in(ccr_in),
      .idx(push_idx), .wdata(mem_wdata)
   );

   seq_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .count(cycle_count)
   );

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (!mem_wr && !pc_load && busy && cycle_count == '0));

endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0;
   logic [15:0] pc_m = 16'h0, x_m = 16'h0, sp_m = 16'h0;
   logic [7:0]  a_m = 8'h0, b_m = 8'h0, ccr_m = 8'hD0;
   logic [7:0]  mem_rdata = 8'h0;
   logic [15:0] mem_addr, pc_value, sp_value;
   logic        mem_rd, mem_wr, pc_load, sp_load, iflag_set, busy;
   logic [7:0]  mem_wdata;
   logic [31:0] cycle_count;

   logic        pre_req = 1'b0;
   logic [15:0] pre_pc, pre_x, pre_sp;
   logic [7:0]  pre_a, pre_b, pre_ccr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   localparam logic [7:0] RHI = 8'hC1, RLO = 8'h23, IHI = 8'hE4, ILO = 8'h56;

   always #5 clk = ~clk;

   irq_entry_seq dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
      .pc_in(pc_m), .x_in(x_m), .a_in(a_m), .b_in(b_m), .ccr_in(ccr_m),
      .sp_in(sp_m), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .pc_load(pc_load), .pc_value(pc_value),
      .sp_load(sp_load), .sp_value(sp_value), .iflag_set(iflag_set),
      .busy(busy), .cycle_count(cycle_count)
   );

   function automatic logic [7:0] rd_fn(input logic [15:0] ad);
      case (ad)
         16'hFFFE: return RHI;
         16'hFFFF: return RLO;
         16'hFFF8: return IHI;
         16'hFFF9: return ILO;
         default:  return ad[7:0] ^ 8'h5A;
      endcase
   endfunction

   // synchronous memory and register-file model
   always @(posedge clk) begin
      mem_rdata <= mem_rd ? rd_fn(mem_addr) : 8'h00;
      if (pre_req) begin
         pc_m <= pre_pc; x_m <= pre_x; sp_m <= pre_sp;
         a_m <= pre_a; b_m <= pre_b; ccr_m <= pre_ccr;
      end else begin
         if (pc_load)   pc_m <= pc_value;
         if (sp_load)   sp_m <= sp_value;
         if (iflag_set) ccr_m[4] <= 1'b1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic preset(input logic [15:0] pc, x, sp, input logic [7:0] a, b, ccr);
      @(negedge clk);
      pre_pc = pc; pre_x = x; pre_sp = sp; pre_a = a; pre_b = b; pre_ccr = ccr;
      pre_req = 1'b1;
      @(negedge clk);
      pre_req = 1'b0;
   endtask

   task automatic test_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(!mem_wr && !pc_load, "R1 no write/load in reset", {mem_wr, pc_load}, 0);
      chk(busy == 1'b1, "R1 busy in reset", busy, 1);
      chk(cycle_count == 0, "R1 counter in reset", cycle_count, 0);
      rst_n = 1'b1;
      #1;
      chk(mem_rd && mem_addr == 16'hFFFE, "R2 first read 0xFFFE", mem_addr, 16'hFFFE);
      chk(cycle_count == 0, "R4 counter zero after release", cycle_count, 0);
      @(negedge clk);
      chk(mem_rd && mem_addr == 16'hFFFF, "R2 second read 0xFFFF", mem_addr, 16'hFFFF);
      chk(cycle_count == 1, "R4 counter step", cycle_count, 1);
      @(negedge clk);
      chk(pc_load && pc_value == {RHI, RLO}, "R2 reset pc load", pc_value, {RHI, RLO});
      chk(iflag_set, "R3 mask set on reset load", iflag_set, 1);
      chk(cycle_count == 2, "R4 counter step", cycle_count, 2);
      @(negedge clk);
      chk(!busy, "R9 idle after reset fetch", busy, 0);
      chk(pc_m == {RHI, RLO}, "R2 pc register", pc_m, {RHI, RLO});
      chk(ccr_m[4], "R3 mask bit in register", ccr_m[4], 1);
   endtask

   task automatic test_masked();
      preset(16'h1000, 16'h2000, 16'h0100, 8'h11, 8'h22, 8'hD0);
      irq_req = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk(!mem_wr && !busy, "R5 masked request ignored", {mem_wr, busy}, 0);
      end
      irq_req = 1'b0;
   endtask

   task automatic run_entry(input logic [15:0] pc, x, sp, input logic [7:0] a, b, ccr);
      logic [7:0]  eb [7];
      logic [31:0] c0;
      eb[0] = pc[7:0]; eb[1] = pc[15:8]; eb[2] = x[7:0]; eb[3] = x[15:8];
      eb[4] = a; eb[5] = b; eb[6] = ccr;
      irq_req = 1'b0;
      preset(pc, x, sp, a, b, ccr);
      irq_req = 1'b1;
      c0 = 32'h0;
      for (int k = 0; k < 7; k++) begin
         @(negedge clk);
         if (k == 0) c0 = cycle_count;
         chk(mem_wr && mem_addr == sp - 16'(k), "R6 push address", mem_addr, sp - 16'(k));
         chk(mem_wdata == eb[k], "R6 push data", mem_wdata, eb[k]);
         chk(sp_load && sp_value == sp - 16'(k + 1), "R7 sp step", sp_value, sp - 16'(k + 1));
         chk(busy, "R9 busy during push", busy, 1);
      end
      @(negedge clk);
      chk(mem_rd && mem_addr == 16'hFFF8, "R8 vector high read", mem_addr, 16'hFFF8);
      @(negedge clk);
      chk(mem_rd && mem_addr == 16'hFFF9, "R8 vector low read", mem_addr, 16'hFFF9);
      @(negedge clk);
      chk(pc_load && pc_value == {IHI, ILO}, "R8 handler pc load", pc_value, {IHI, ILO});
      chk(iflag_set && busy, "R3 mask set with busy", {iflag_set, busy}, 2'b11);
      chk(cycle_count == c0 + 9, "R4 entry cycle span", cycle_count, c0 + 9);
      @(negedge clk);
      chk(!busy, "R9 busy drops after load", busy, 0);
      chk(sp_m == sp - 16'd7, "R7 final sp", sp_m, sp - 16'd7);
      chk(pc_m == {IHI, ILO}, "R8 pc register", pc_m, {IHI, ILO});
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(!mem_wr && !busy, "R9 held request ignored while masked", {mem_wr, busy}, 0);
      end
   endtask

   task automatic test_reenable();
      logic [15:0] s;
      s = sp_m;
      preset(pc_m, x_m, s, a_m, b_m, ccr_m & 8'hEF);
      @(negedge clk);
      chk(mem_wr && mem_addr == s, "R9 entry after mask cleared", mem_addr, s);
      for (int k = 0; k < 20 && busy; k++) @(negedge clk);
      chk(!busy, "R9 re-entry completes", busy, 0);
      irq_req = 1'b0;
   endtask

   task automatic test_reset_mid();
      irq_req = 1'b0;
      preset(16'h4444, 16'h5555, 16'h0200, 8'h66, 8'h77, 8'hC0);
      irq_req = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(!mem_wr, "R10 reset stops push", mem_wr, 0);
      irq_req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(mem_rd && mem_addr == 16'hFFFE, "R10 restart at reset fetch", mem_addr, 16'hFFFE);
      repeat (3) @(negedge clk);
   endtask

   task automatic test_coincide();
      preset(16'h0000, 16'h0000, 16'h0300, 8'h00, 8'h00, 8'hC0);
      irq_req = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(pc_m == {RHI, RLO} && ccr_m[4], "R3 reset load wins over pending request",
          {pc_m, 7'h0, ccr_m[4]}, {RHI, RLO, 8'h01});
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(!mem_wr && !busy, "R5 pending request masked after reset", {mem_wr, busy}, 0);
      end
      irq_req = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      pre_pc = 0; pre_x = 0; pre_sp = 0; pre_a = 0; pre_b = 0; pre_ccr = 0;
      test_reset();
      test_masked();
      run_entry(16'h8A3C, 16'h1F2E, 16'h01FF, 8'hA5, 8'h5B, 8'hC3);
      run_entry(16'h0102, 16'hFEDC, 16'h0003, 8'h0F, 8'hF0, 8'hE9);
      test_reenable();
      test_reset_mid();
      test_coincide();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule